// File: doc/BRIEF.md
# Bus-master PRD DMA engine

This block is the data mover of one disk channel. Software writes the address of a descriptor table, then sets the start bit in the command byte. The engine reads descriptors from memory one after another. Each descriptor names a physical region and its byte length. For each region in turn, the engine carries bytes between a word-wide memory port and a byte stream to the device. Command bit 3 sets the direction.

The engine never learns how long the device transfer is. It ends the run from two events: the table running out, and the device raising its done strobe. The order of those two events decides the final status. If the table runs out while the device still wants data, both status bits clear, which is the error outcome. If the device finishes exactly as the table ends, only the interrupt bit is left set. If the device finishes with table space left, both the active and the interrupt bits stay set until software writes a stop command.

Both device streams use valid/ready handshakes. A byte moves only in a cycle where valid and ready are both high. `din_ready` and `dout_valid` are low whenever no region is being transferred. The device holds `din_data` and `din_valid` until the byte is taken, and may hold `dout_ready` low for as long as it needs. The memory port works the same way: a request is granted in a cycle where `mem_valid` and `mem_ready` are both high, and read data must be valid in that same cycle.

Top module: `prd_dma_engine`

## Requirements
- R1: A descriptor is two 32-bit little-endian words at byte offsets +0 and +4. The first word is the region address. In the second word, bits 15:0 are the byte count and bit 31 set marks the last descriptor. Descriptors are read in ascending order, 8 bytes apart, starting from the table pointer with its low 2 bits forced to zero.
- R2: Bit 0 of the byte count is treated as zero, and an effective count of zero means 65536 bytes.
- R3: A command write with bit 0 = 1 starts a run, but only from idle. Command bit 3 = 1 moves bytes from the device to memory; bit 3 = 0 moves bytes from memory to the device. Bytes move in stream order to consecutive addresses, region after region. Each memory write carries one byte, with the byte enable `1 << addr[1:0]`.
- R4: A byte moves only in a cycle where both valid and ready are high. Memory bytes outside the transferred range are never written. While `dout_valid` is high, `dout_data` does not change.
- R5: If the table ends and the device then still offers or asks for data (`din_valid`, or `dout_ready`) before its done strobe, the run ends with status bit 0 (active) and status bit 2 (interrupt) both clear. No further byte is accepted.
- R6: If the device done strobe arrives after the last byte of the last region, the run ends with status = 0x04 (interrupt set, active clear).
- R7: If the done strobe arrives while table space remains, status = 0x05 (interrupt and active set). No further data moves until a stop command.
- R8: A command write with bit 0 = 0 makes the engine idle at the next edge: active clears, and no byte moves after that. The interrupt bit keeps its value.
- R9: The `irq` output always equals status bit 2. The bit is set by an accepted done strobe and cleared by a status write with bit 2 = 1; other bits of that write have no effect. The set wins if both happen in the same cycle.
- R10: After reset, status = 0x00, `irq` = 0, and no memory request or stream handshake is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_wdata | input | 8 | Command byte: bit 0 start, bit 3 device-to-memory |
| sts_wr | input | 1 | Status write strobe |
| sts_wdata | input | 8 | Status write data: bit 2 = 1 clears the interrupt |
| tbl_ptr | input | ADDR_W | Descriptor table address, sampled at start |
| status | output | 8 | Bit 0 active, bit 2 interrupt, other bits zero |
| irq | output | 1 | Interrupt request, equal to status bit 2 |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 4 | Byte enables for a write |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | 32 | Read data, valid in the accept cycle |
| din_valid | input | 1 | Device offers a byte (device to memory) |
| din_ready | output | 1 | Engine takes the offered byte |
| din_data | input | 8 | Byte from the device |
| dout_valid | output | 1 | Engine offers a byte (memory to device) |
| dout_ready | input | 1 | Device takes the offered byte |
| dout_data | output | 8 | Byte to the device |
| dev_done | input | 1 | One-cycle strobe: the device transfer is complete |

## Verification
The bench builds the engine with its default 32-bit address. The table is kept inside a 512-byte memory model, and the memory grants requests on only two cycles out of three, so back-pressure is exercised throughout. It uses table layouts of one, two and three regions, some with odd counts. For each layout it sweeps the device length from 2 to 12 bytes in both directions. This reaches the shorter, equal and longer outcomes at several region boundaries. Single-descriptor runs with counts of 0, 1 and 3 show the 64 KiB meaning of zero and the dropped low bit. Stops issued in mid-run and after completion cover the abort rules.

// File: rtl/prd_dma_pkg.sv
`timescale 1ns/1ps
package prd_dma_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LANES    = WORD_W / 8;
  localparam int unsigned LANE_W   = $clog2(LANES);
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned LEN_W    = CNT_W + 1;
  localparam int unsigned LAST_BIT = 31;
  localparam int unsigned DESC_STEP = 8;
  localparam int unsigned CMD_GO_BIT  = 0;
  localparam int unsigned CMD_DIR_BIT = 3;
  localparam int unsigned STS_ACT_BIT = 0;
  localparam int unsigned STS_INT_BIT = 2;

  typedef enum logic [2:0] {
    S_IDLE, S_DESC_ADDR, S_DESC_CNT, S_MOVE, S_DRAIN, S_HOLD
  } ctl_state_e;
endpackage

// File: rtl/prd_dma_mover.sv
`timescale 1ns/1ps
module prd_dma_mover
  import prd_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [LEN_W-1:0]  load_len,
  input  logic              flush,
  input  logic              run,
  input  logic              to_mem,
  output logic              region_empty,
  output logic              mreq,
  output logic              mwe,
  output logic [ADDR_W-1:0] maddr,
  output logic [LANES-1:0]  mbe,
  output logic [WORD_W-1:0] mwdata,
  input  logic              mready,
  input  logic [WORD_W-1:0] mrdata,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [7:0]        din_data,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [7:0]        dout_data
);
  logic [ADDR_W-1:0] cur;
  logic [LEN_W-1:0]  rem;
  logic [WORD_W-1:0] rbuf;
  logic              rbuf_vld;
  logic [LANE_W-1:0] lane;
  logic              has, in_take, out_take, fill, step;

  assign lane = cur[LANE_W-1:0];
  assign has  = run && (rem != '0);

  always_comb begin
    mreq       = 1'b0;
    mwe        = 1'b0;
    maddr      = {cur[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    mbe        = '0;
    mwdata     = {LANES{din_data}};
    din_ready  = 1'b0;
    dout_valid = 1'b0;
    if (has) begin
      if (to_mem) begin
        mreq      = din_valid;
        mwe       = 1'b1;
        mbe       = LANES'(1) << lane;
        din_ready = mready;
      end else begin
        mreq       = !rbuf_vld;
        dout_valid = rbuf_vld;
      end
    end
  end

  assign dout_data    = rbuf[{lane, 3'b000} +: 8];
  assign in_take      = has && to_mem && din_valid && mready;
  assign out_take     = has && !to_mem && rbuf_vld && dout_ready;
  assign fill         = has && !to_mem && !rbuf_vld && mready;
  assign step         = in_take || out_take;
  assign region_empty = (rem == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      rem      <= '0;
      rbuf     <= '0;
      rbuf_vld <= 1'b0;
    end else if (flush) begin
      rem      <= '0;
      rbuf_vld <= 1'b0;
    end else if (load) begin
      cur      <= load_addr;
      rem      <= load_len;
      rbuf_vld <= 1'b0;
    end else begin
      if (fill) begin
        rbuf     <= mrdata;
        rbuf_vld <= 1'b1;
      end
      if (step) begin
        cur <= cur + ADDR_W'(1);
        rem <= rem - LEN_W'(1);
      end
      if (out_take && (lane == LANE_W'(LANES - 1) || rem == LEN_W'(1)))
        rbuf_vld <= 1'b0;
    end
  end

  // R3: every accepted byte consumes exactly one byte of the region
  assert_step_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !flush) |=> (rem == $past(rem) - LEN_W'(1)));

  // R4: an offered byte keeps its value until taken
  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready && !flush && !load) |=> (!dout_valid || $stable(dout_data)));
endmodule

// File: rtl/prd_dma_ctrl.sv
`timescale 1ns/1ps
module prd_dma_ctrl
  import prd_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_wdata,
  input  logic              sts_wr,
  input  logic [7:0]        sts_wdata,
  input  logic [ADDR_W-1:0] tbl_ptr,
  input  logic              dev_done,
  input  logic              dev_demand,
  input  logic              region_empty,
  output logic              fetch_req,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic              mready,
  input  logic [WORD_W-1:0] mrdata,
  output logic              ld_pulse,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [LEN_W-1:0]  ld_len,
  output logic              run,
  output logic              to_mem,
  output logic              flush,
  output logic              active,
  output logic              irq
);
  ctl_state_e        state, nxt;
  logic [ADDR_W-1:0] ptr;
  logic [ADDR_W-1:0] reg_addr;
  logic              last_q, dir_q, irq_q;
  logic              stop, start, take_done;
  logic [CNT_W-1:0]  cnt_even;
  logic              unused_bits;

  assign unused_bits = ^{cmd_wdata[7:4], cmd_wdata[2:1], sts_wdata[7:3], sts_wdata[1:0]};

  assign stop      = cmd_wr && !cmd_wdata[CMD_GO_BIT];
  assign start     = cmd_wr && cmd_wdata[CMD_GO_BIT] && (state == S_IDLE);
  assign take_done = dev_done && (state == S_DESC_ADDR || state == S_DESC_CNT ||
                                  state == S_MOVE || state == S_DRAIN);

  assign cnt_even   = {mrdata[CNT_W-1:1], 1'b0};
  assign ld_len     = (cnt_even == '0) ? LEN_W'(1 << CNT_W) : {1'b0, cnt_even};
  assign ld_addr    = reg_addr;
  assign ld_pulse   = (state == S_DESC_CNT) && mready && !take_done && !stop;
  assign fetch_req  = (state == S_DESC_ADDR) || (state == S_DESC_CNT);
  assign fetch_addr = (state == S_DESC_CNT) ? ptr + ADDR_W'(4) : ptr;
  assign run        = (state == S_MOVE);
  assign to_mem     = dir_q;
  assign flush      = stop;
  assign active     = (state != S_IDLE);
  assign irq        = irq_q;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:      if (start) nxt = S_DESC_ADDR;
      S_DESC_ADDR: if (take_done) nxt = S_HOLD; else if (mready) nxt = S_DESC_CNT;
      S_DESC_CNT:  if (take_done) nxt = S_HOLD; else if (mready) nxt = S_MOVE;
      S_MOVE: begin
        if (region_empty) begin
          if (last_q) nxt = take_done ? S_IDLE : S_DRAIN;
          else        nxt = take_done ? S_HOLD : S_DESC_ADDR;
        end else if (take_done) begin
          nxt = S_HOLD;
        end
      end
      S_DRAIN:     if (take_done || dev_demand) nxt = S_IDLE;
      S_HOLD:      nxt = S_HOLD;
      default:     nxt = S_IDLE;
    endcase
    if (stop) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ptr      <= '0;
      reg_addr <= '0;
      last_q   <= 1'b0;
      dir_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      state <= nxt;
      if (start) begin
        ptr   <= {tbl_ptr[ADDR_W-1:2], 2'b00};
        dir_q <= cmd_wdata[CMD_DIR_BIT];
      end
      if (state == S_DESC_ADDR && mready && !take_done)
        reg_addr <= ADDR_W'(mrdata);
      if (ld_pulse) begin
        last_q <= mrdata[LAST_BIT];
        ptr    <= ptr + ADDR_W'(DESC_STEP);
      end
      if (take_done)
        irq_q <= 1'b1;
      else if (sts_wr && sts_wdata[STS_INT_BIT])
        irq_q <= 1'b0;
    end
  end

  // R8: a stop command idles the engine at the next edge
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !active);

  // R9: the interrupt only rises after a device done strobe
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(dev_done));

  // R7: the finished-early state holds until a stop
  assert_hold_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_HOLD && !stop) |=> (state == S_HOLD && active));

  // R5: a demand after the table ended closes the run without interrupt
  assert_drain_underrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DRAIN && dev_demand && !dev_done) |=> (!active && (irq_q == $past(irq_q))));
endmodule

// File: rtl/prd_dma_engine.sv
`timescale 1ns/1ps
module prd_dma_engine
  import prd_dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [7:0]        cmd_wdata,
  input  logic              sts_wr,
  input  logic [7:0]        sts_wdata,
  input  logic [ADDR_W-1:0] tbl_ptr,
  output logic [7:0]        status,
  output logic              irq,
  output logic              mem_valid,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ready,
  input  logic [31:0]       mem_rdata,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [7:0]        din_data,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [7:0]        dout_data,
  input  logic              dev_done
);
  logic              f_req, mv_req, mv_we, mv_ready;
  logic [ADDR_W-1:0] f_addr, mv_addr, ld_addr;
  logic [LANES-1:0]  mv_be;
  logic [WORD_W-1:0] mv_wdata;
  logic [LEN_W-1:0]  ld_len;
  logic              ld_pulse, run, to_mem, flush, active, region_empty, demand;

  assign demand = to_mem ? din_valid : dout_ready;

  prd_dma_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .tbl_ptr(tbl_ptr), .dev_done(dev_done), .dev_demand(demand),
    .region_empty(region_empty),
    .fetch_req(f_req), .fetch_addr(f_addr),
    .mready(mem_ready), .mrdata(mem_rdata),
    .ld_pulse(ld_pulse), .ld_addr(ld_addr), .ld_len(ld_len),
    .run(run), .to_mem(to_mem), .flush(flush),
    .active(active), .irq(irq)
  );

  assign mv_ready = mem_ready && !f_req;

  prd_dma_mover #(.ADDR_W(ADDR_W)) u_mover (
    .clk(clk), .rst_n(rst_n),
    .load(ld_pulse), .load_addr(ld_addr), .load_len(ld_len),
    .flush(flush), .run(run), .to_mem(to_mem),
    .region_empty(region_empty),
    .mreq(mv_req), .mwe(mv_we), .maddr(mv_addr), .mbe(mv_be),
    .mwdata(mv_wdata), .mready(mv_ready), .mrdata(mem_rdata),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data)
  );

  assign mem_valid = f_req || mv_req;
  assign mem_we    = f_req ? 1'b0 : mv_we;
  assign mem_addr  = f_req ? f_addr : mv_addr;
  assign mem_be    = f_req ? 4'hF : mv_be;
  assign mem_wdata = mv_wdata;

  always_comb begin
    status = 8'h00;
    status[STS_ACT_BIT] = active;
    status[STS_INT_BIT] = irq;
  end

  // R1: descriptor reads and data moves never compete for the memory port
  assert_one_master_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(f_req && mv_req));

  // R1: descriptor words are read from word-aligned addresses
  assert_desc_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    f_req |-> (f_addr[1:0] == 2'b00));
endmodule

// File: tb/prd_dma_engine_test.sv
`timescale 1ns/1ps
module prd_dma_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wr = 1'b0, sts_wr = 1'b0;
  logic [7:0]  cmd_wdata = 8'h00, sts_wdata = 8'h00;
  logic [31:0] tbl_ptr = 32'h0;
  logic [7:0]  status;
  logic        irq;
  logic        mem_valid, mem_we;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata;
  logic        mem_ready = 1'b0;
  logic        din_valid = 1'b0, din_ready;
  logic [7:0]  din_data = 8'h00;
  logic        dout_valid, dout_ready = 1'b0;
  logic [7:0]  dout_data;
  logic        dev_done = 1'b0;

  logic [7:0]  mem [0:511];
  logic [7:0]  rx  [0:63];
  int nchk = 0, nerr = 0;
  bit finished = 1'b0;
  int nent;
  int cnts [0:2];

  always #4 clk = ~clk;

  assign mem_rdata = {mem[{mem_addr[8:2], 2'b11}], mem[{mem_addr[8:2], 2'b10}],
                      mem[{mem_addr[8:2], 2'b01}], mem[{mem_addr[8:2], 2'b00}]};

  prd_dma_engine uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .tbl_ptr(tbl_ptr),
    .status(status), .irq(irq),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_data(dout_data),
    .dev_done(dev_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int eff(input int c);
    int e = c & 32'hFFFE;
    return (e == 0) ? 65536 : e;
  endfunction

  function automatic int ptotal();
    int t = 0;
    for (int k = 0; k < nent; k++) t += eff(cnts[k]);
    return t;
  endfunction

  function automatic int addr_of(input int pos);
    int p = pos;
    for (int k = 0; k < nent; k++) begin
      if (p < eff(cnts[k])) return 'h101 + k * 'h40 + p;
      if (k == nent - 1) return 'h101 + k * 'h40 + p;
      p -= eff(cnts[k]);
    end
    return 0;
  endfunction

  task automatic setup_table(input bit to_mem);
    for (int a = 'h100; a < 'h200; a++) mem[a] = to_mem ? 8'hEE : (8'(a) ^ 8'h5A);
    for (int a = 0; a < 64; a++) rx[a] = 8'h00;
    for (int k = 0; k < nent; k++) begin
      int ra = 'h101 + k * 'h40;
      int cw = cnts[k] | ((k == nent - 1) ? 32'h8000_0000 : 0);
      for (int b = 0; b < 4; b++) begin
        mem['h40 + 8 * k + b]     = 8'(ra >> (8 * b));
        mem['h40 + 8 * k + 4 + b] = 8'(cw >> (8 * b));
      end
    end
  endtask

  task automatic do_run(input bit to_mem, input int len, input int ptr_lo,
                        input int stop_at, input int cycles,
                        output int moved, output int post);
    int cnt = 0;
    bit sent = 1'b0;
    post = 0;
    @(negedge clk);
    cmd_wr = 1'b1;
    cmd_wdata = to_mem ? 8'h09 : 8'h01;
    tbl_ptr = 32'h40 | ptr_lo;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      cmd_wr    = (c == stop_at);
      cmd_wdata = 8'h00;
      mem_ready = (c % 3 != 1);
      din_valid = to_mem && (cnt < len);
      din_data  = 8'hA0 + 8'(cnt);
      dout_ready = !to_mem && (cnt < len);
      dev_done  = (cnt == len) && !sent;
      if (dev_done) sent = 1'b1;
      #1;
      if (mem_valid && mem_ready && mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) mem[{mem_addr[8:2], 2'(b)}] = mem_wdata[8*b +: 8];
      if (din_valid && din_ready) begin
        cnt++;
        if (stop_at >= 0 && c > stop_at) post++;
      end
      if (dout_valid && dout_ready) begin
        if (cnt < 64) rx[cnt] = dout_data;
        cnt++;
        if (stop_at >= 0 && c > stop_at) post++;
      end
    end
    @(negedge clk);
    mem_ready = 1'b0;
    dev_done = 1'b0;
    moved = cnt;
  endtask

  task automatic wr_cmd(input logic [7:0] v);
    @(negedge clk); cmd_wr = 1'b1; cmd_wdata = v;
    @(negedge clk); cmd_wr = 1'b0; cmd_wdata = 8'h00;
  endtask

  task automatic wr_sts(input logic [7:0] v);
    @(negedge clk); sts_wr = 1'b1; sts_wdata = v;
    @(negedge clk); sts_wr = 1'b0; sts_wdata = 8'h00;
  endtask

  task automatic end_run();
    din_valid = 1'b0; dout_ready = 1'b0;
    wr_cmd(8'h00);
    wr_sts(8'h04);
  endtask

  task automatic sweep_one(input bit to_mem, input int len, input int ptr_lo);
    int moved, post, p, expm, bad;
    logic [7:0] exps;
    string tag;
    p = ptotal();
    setup_table(to_mem);
    do_run(to_mem, len, ptr_lo, -1, 120, moved, post);
    expm = (p < len) ? p : len;
    exps = (p < len) ? 8'h00 : (p == len) ? 8'h04 : 8'h05;
    tag  = (p < len) ? "R5" : (p == len) ? "R6" : "R7";
    chk(status == exps, tag, "final status", status, exps);
    chk(irq == exps[2], "R9", "irq pin", irq, exps[2]);
    chk(moved == expm, "R3", "bytes moved", moved, expm);
    bad = 0;
    for (int n = 0; n < expm; n++) begin
      if (to_mem) begin
        if (mem[addr_of(n)] != 8'hA0 + 8'(n)) bad++;
      end else if (rx[n] != (8'(addr_of(n)) ^ 8'h5A)) bad++;
    end
    chk(bad == 0, "R1", "bytes in descriptor order", bad, 0);
    if (to_mem) chk(mem[addr_of(expm)] == 8'hEE, "R4", "byte past range untouched",
                    mem[addr_of(expm)], 8'hEE);
    if (p < len) chk(!din_ready && !dout_valid, "R5", "no acceptance after underrun",
                     {din_ready, dout_valid}, 0);
    din_valid = 1'b0; dout_ready = 1'b0;
    wr_cmd(8'h00);
    chk(status == (exps & 8'h04), "R8", "status after stop", status, exps & 8'h04);
    wr_sts(8'h04);
    chk(status == 8'h00 && !irq, "R9", "cleared by status write", status, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int moved, post;
    for (int a = 0; a < 512; a++) mem[a] = 8'h00;
    repeat (3) @(negedge clk);
    chk(status == 8'h00 && !irq, "R10", "status in reset", status, 0);
    chk(!mem_valid && !din_ready && !dout_valid, "R10", "quiet ports in reset",
        {mem_valid, din_ready, dout_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(status == 8'h00 && !mem_valid, "R10", "status after reset", status, 0);

    // sweep: three table layouts x device lengths x both directions
    for (int dir = 0; dir < 2; dir++)
      for (int lay = 0; lay < 3; lay++)
        for (int len = 2; len <= 12; len += 2) begin
          case (lay)
            0: begin nent = 1; cnts[0] = 8; end
            1: begin nent = 2; cnts[0] = 3; cnts[1] = 6; end
            default: begin nent = 3; cnts[0] = 4; cnts[1] = 2; cnts[2] = 4; end
          endcase
          sweep_one(dir[0], len, (lay == 1) ? 3 : 0);
        end

    // R2: count of zero and of one means 64 KiB; odd count drops bit 0
    nent = 1; cnts[0] = 0; sweep_one(1'b1, 6, 0);
    nent = 1; cnts[0] = 1; sweep_one(1'b0, 6, 0);
    nent = 1; cnts[0] = 3;
    setup_table(1'b1);
    do_run(1'b1, 2, 0, -1, 80, moved, post);
    chk(status == 8'h04, "R2", "count 3 acts as 2 (equal)", status, 8'h04);
    end_run();
    setup_table(1'b1);
    do_run(1'b1, 4, 0, -1, 80, moved, post);
    chk(status == 8'h00 && moved == 2, "R2", "count 3 acts as 2 (short)", moved, 2);
    end_run();

    // R8: stop in mid-run, both directions
    for (int dir = 0; dir < 2; dir++) begin
      nent = 1; cnts[0] = 20;
      setup_table(dir[0]);
      do_run(dir[0], 20, 0, 12, 100, moved, post);
      chk(status == 8'h00 && !irq, "R8", "status after mid-run stop", status, 0);
      chk(post == 0, "R8", "bytes moved after stop", post, 0);
      chk(moved > 0 && moved < 20, "R8", "partial transfer", moved, 10);
      end_run();
    end

    // R9: status write without bit 2 leaves the interrupt alone
    nent = 1; cnts[0] = 4;
    setup_table(1'b1);
    do_run(1'b1, 4, 0, -1, 60, moved, post);
    wr_sts(8'hFB);
    chk(status == 8'h04 && irq, "R9", "write without bit 2 ignored", status, 8'h04);
    wr_sts(8'h04);
    chk(status == 8'h00 && !irq, "R9", "write with bit 2 clears", status, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule